// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a blocking data cache placed between a processor load/store port and a wider memory port. Each of its 1024 lines holds four 32-bit words (16 bytes), giving 16 KB of cached data, and every memory location has exactly one line it can occupy. Stores that hit change only the cached copy and mark the line modified. A modified line goes back to memory only when another block needs its slot.

The processor raises `cpu_valid` with a read/write flag, a byte address and store data. It keeps them steady until `cpu_ready` pulses. Misses are handled by a small controller with four states: idle, tag check, eviction and refill. On a miss, the controller first writes a modified victim out as a full 128-bit line. It then fetches the requested line. Last, it returns to the tag check, so the access finishes exactly like a hit. Store misses allocate the line in the same way.

The memory side uses the same valid/ready handshake with whole-line transfers. The processor port has only one access in flight at a time.

Top module: `dm_wb_cache`

## Requirements
- R1: After reset, `cpu_ready` and `mem_valid` are 0. Every line is invalid and clean, so the first access to any line after reset fetches it and never writes anything back.
- R2: Byte address bits [31:14] form the tag, bits [13:4] select one of 1024 lines, and bits [3:2] select the word. Addresses that differ only in the tag share a line and displace each other, including at line index 1023.
- R3: A read hit raises `cpu_ready` on the second clock edge after the request is sampled. `cpu_rdata` then carries the stored word, and there is no memory traffic.
- R4: A write hit (`cpu_rw`=1) changes only the cached word, produces no memory traffic and marks the line modified.
- R5: A miss whose victim is invalid or clean issues exactly one memory read (`mem_rw`=0). The read address is the request address with bits [3:0] cleared, and no memory write is issued.
- R6: A write miss first fetches the line and then stores the word into it. The other three words of that line keep the values held in memory.
- R7: A miss whose victim is modified first issues a memory write (`mem_rw`=1). Its address is {stored tag, index, 4'b0000} and its data is the full 128-bit victim line. The refill read follows directly after this write.
- R8: After the refill read completes, `mem_valid` drops on the next cycle, and `cpu_ready` pulses on the cycle after that.
- R9: The cache is blocking. `cpu_ready` rises only after all memory transfers of the access have finished, a miss takes at least four cycles, and `mem_valid` is never high while `cpu_ready` is high.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_rw` and (for writes) `mem_wdata` hold their values.
- R11: `cpu_ready` is a single-cycle pulse, one for each access.
- R12: Address bits [1:0] are ignored. A store to a byte address updates the whole aligned word that contains it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Access request, held until `cpu_ready` |
| cpu_rw | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory transfer request |
| mem_rw | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | 32 | Line-aligned byte address |
| mem_wdata | output | 128 | Victim line data |
| mem_rdata | input | 128 | Refill line data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory transfer complete |

## Verification
The bound checker checks the protocol rules on every cycle: completion is a single pulse, memory request fields stay steady until accepted, and memory addresses are line aligned. It also checks the ordering rules: a write-back is always followed directly by a refill, a refill always leads to completion two cycles later, and there is no memory request during completion. Only the bench scenarios can show the rest. That covers what data comes back, which memory addresses and victim lines appear for hits and for clean or modified victims, how tags alias onto the same index, whether the byte offset is ignored, and whether the line state is lost across reset. They need a reference memory image that the checker does not have.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COMPARE = 2'd1,
    ST_EVICT   = 2'd2,
    ST_REFILL  = 2'd3
  } cache_state_e;

endpackage

// File: rtl/cache_line_ram.sv
// Single-port synchronous RAM, write-first on a shared address.
module cache_line_ram #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[addr] <= wdata;
      rdata       <= wdata;
    end else begin
      rdata <= store[addr];
    end
  end

endmodule

// File: rtl/cache_line_flags.sv
// Per-line present and modified bits, held in flops so reset can clear them.
module cache_line_flags #(
  parameter int LINES = 1024,
  localparam int IW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] idx,
  input  logic          fill,
  input  logic          mark_dirty,
  output logic          present,
  output logic          modified
);

  logic [LINES-1:0] present_q;
  logic [LINES-1:0] modified_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      present_q  <= '0;
      modified_q <= '0;
    end else if (fill) begin
      present_q[idx]  <= 1'b1;
      modified_q[idx] <= 1'b0;
    end else if (mark_dirty) begin
      modified_q[idx] <= 1'b1;
    end
  end

  assign present  = present_q[idx];
  assign modified = modified_q[idx];

endmodule

// File: rtl/cache_ctrl.sv
// Controller and datapath: request capture, tag check, word merge, memory sequencing.
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 1024,
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int BYTE_W = $clog2(WORD_W / 8),
  localparam int WSEL_W = $clog2(LINE_WORDS),
  localparam int OFF_W  = BYTE_W + WSEL_W,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [IDX_W-1:0]  ram_idx,
  output logic              data_we,
  output logic [LINE_W-1:0] data_wd,
  input  logic [LINE_W-1:0] data_rd,
  output logic              tag_we,
  output logic [TAG_W-1:0]  tag_wd,
  input  logic [TAG_W-1:0]  tag_rd,
  output logic              line_fill,
  output logic              line_mark,
  input  logic              line_present,
  input  logic              line_modified,
  output cache_state_e      state
);

  cache_state_e state_q, state_d;

  logic              req_rw_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [WORD_W-1:0] req_wdata_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WSEL_W-1:0] req_word;
  logic              hit;
  logic              victim_dirty;
  logic [LINE_W-1:0] merged;
  logic [WORD_W-1:0] hit_word;

  assign req_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr_q[OFF_W +: IDX_W];
  assign req_word = req_addr_q[BYTE_W +: WSEL_W];

  assign hit          = line_present && (tag_rd == req_tag);
  assign victim_dirty = line_present && line_modified;
  assign hit_word     = data_rd[req_word*WORD_W +: WORD_W];

  generate
    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_merge
      assign merged[w*WORD_W +: WORD_W] =
        (req_word == WSEL_W'(w)) ? req_wdata_q : data_rd[w*WORD_W +: WORD_W];
    end
  endgenerate

  // RAM address: the incoming request while idle, the held request otherwise.
  assign ram_idx = (state_q == ST_IDLE) ? cpu_addr[OFF_W +: IDX_W] : req_idx;

  assign data_we   = ((state_q == ST_COMPARE) && hit && req_rw_q) ||
                     ((state_q == ST_REFILL) && mem_ready);
  assign data_wd   = (state_q == ST_REFILL) ? mem_rdata : merged;
  assign tag_we    = (state_q == ST_REFILL) && mem_ready;
  assign tag_wd    = req_tag;
  assign line_fill = tag_we;
  assign line_mark = (state_q == ST_COMPARE) && hit && req_rw_q;
  assign state     = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (cpu_valid) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (hit)               state_d = ST_IDLE;
        else if (victim_dirty) state_d = ST_EVICT;
        else                   state_d = ST_REFILL;
      end
      ST_EVICT:   if (mem_ready) state_d = ST_REFILL;
      ST_REFILL:  if (mem_ready) state_d = ST_COMPARE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      req_rw_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      cpu_ready   <= 1'b0;
      cpu_rdata   <= '0;
      mem_valid   <= 1'b0;
      mem_rw      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      state_q   <= state_d;
      cpu_ready <= 1'b0;
      if (state_q == ST_IDLE && cpu_valid) begin
        req_rw_q    <= cpu_rw;
        req_addr_q  <= cpu_addr;
        req_wdata_q <= cpu_wdata;
      end
      unique case (state_q)
        ST_COMPARE: begin
          if (hit) begin
            cpu_ready <= 1'b1;
            if (!req_rw_q) cpu_rdata <= hit_word;
          end else if (victim_dirty) begin
            mem_valid <= 1'b1;
            mem_rw    <= 1'b1;
            mem_addr  <= {tag_rd, req_idx, {OFF_W{1'b0}}};
            mem_wdata <= data_rd;
          end else begin
            mem_valid <= 1'b1;
            mem_rw    <= 1'b0;
            mem_addr  <= {req_tag, req_idx, {OFF_W{1'b0}}};
          end
        end
        ST_EVICT: begin
          if (mem_ready) begin
            mem_rw   <= 1'b0;
            mem_addr <= {req_tag, req_idx, {OFF_W{1'b0}}};
          end
        end
        ST_REFILL: begin
          if (mem_ready) mem_valid <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 1024,
  localparam int LINE_W = WORD_W * LINE_WORDS,
  localparam int OFF_W  = $clog2(LINE_W / 8),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  input  logic              cpu_rw,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_valid,
  output logic              mem_rw,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ready
);

  logic [IDX_W-1:0]  ram_idx;
  logic              data_we;
  logic [LINE_W-1:0] data_wd;
  logic [LINE_W-1:0] data_rd;
  logic              tag_we;
  logic [TAG_W-1:0]  tag_wd;
  logic [TAG_W-1:0]  tag_rd;
  logic              line_fill;
  logic              line_mark;
  logic              line_present;
  logic              line_modified;
  cache_state_e      state;

  cache_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_rw(cpu_rw), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_valid(mem_valid), .mem_rw(mem_rw), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .ram_idx(ram_idx), .data_we(data_we), .data_wd(data_wd), .data_rd(data_rd),
    .tag_we(tag_we), .tag_wd(tag_wd), .tag_rd(tag_rd),
    .line_fill(line_fill), .line_mark(line_mark),
    .line_present(line_present), .line_modified(line_modified),
    .state(state)
  );

  cache_line_ram #(.DEPTH(LINES), .WIDTH(LINE_W)) u_data (
    .clk(clk), .addr(ram_idx), .we(data_we), .wdata(data_wd), .rdata(data_rd)
  );

  cache_line_ram #(.DEPTH(LINES), .WIDTH(TAG_W)) u_tags (
    .clk(clk), .addr(ram_idx), .we(tag_we), .wdata(tag_wd), .rdata(tag_rd)
  );

  cache_line_flags #(.LINES(LINES)) u_flags (
    .clk(clk), .rst(rst), .idx(ram_idx), .fill(line_fill), .mark_dirty(line_mark),
    .present(line_present), .modified(line_modified)
  );

endmodule

// File: rtl/cache_chk.sv
module cache_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  localparam int OFF_W = $clog2(LINE_W / 8)
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_rw,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LINE_W-1:0] mem_wdata
);

  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_rw)));

  p_wdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_rw && !mem_ready) |=> $stable(mem_wdata));

  p_line_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[OFF_W-1:0] == '0));

  p_evict_then_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_rw && mem_ready) |=> (mem_valid && !mem_rw));

  p_fill_then_done_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_rw && mem_ready) |=> !mem_valid ##1 cpu_ready);

  p_quiet_on_done_r9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !mem_valid);

endmodule

bind dm_wb_cache cache_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_rw(mem_rw), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/dm_wb_cache_tb.sv
module dm_wb_cache_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_valid = 1'b0;
  logic         cpu_rw = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [31:0]  cpu_rdata;
  logic         cpu_ready;
  logic         mem_valid;
  logic         mem_rw;
  logic [31:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic [127:0] mem_rdata = '0;
  logic         mem_ready = 1'b0;

  always #2.5 clk = ~clk;

  dm_wb_cache u_dut (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_rw(cpu_rw),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_valid(mem_valid), .mem_rw(mem_rw),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // Reference image of every stored word, keyed by aligned word address.
  logic [31:0]  gold   [logic [31:0]];
  // Backing memory, keyed by line address.
  logic [127:0] mstore [logic [31:0]];

  // Transfer log for one access.
  int           log_n = 0;
  logic         log_rw   [8];
  logic [31:0]  log_addr [8];
  logic [127:0] log_data [8];

  function automatic logic [31:0] dflt(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC0DE_0000;
  endfunction

  function automatic logic [31:0] gword(input logic [31:0] a);
    logic [31:0] k = {a[31:2], 2'b00};
    return gold.exists(k) ? gold[k] : dflt(k);
  endfunction

  function automatic logic [127:0] gline(input logic [31:0] la);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = gword(la + 32'(w*4));
    return l;
  endfunction

  function automatic logic [127:0] mline(input logic [31:0] la);
    logic [127:0] l;
    if (mstore.exists(la)) return mstore[la];
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = dflt(la + 32'(w*4));
    return l;
  endfunction

  // Memory model: answers each request after a latency that rotates 0..3.
  initial begin
    int cnt = 0;
    int lat = 1;
    forever begin
      @(negedge clk);
      mem_ready = 1'b0;
      if (mem_valid && !rst) begin
        if (cnt >= lat) begin
          if (log_n < 8) begin
            log_rw[log_n]   = mem_rw;
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_wdata;
          end
          log_n++;
          if (mem_rw) mstore[mem_addr] = mem_wdata;
          else        mem_rdata = mline(mem_addr);
          mem_ready = 1'b1;
          cnt = 0;
          lat = (lat + 1) % 4;
        end else begin
          cnt++;
        end
      end else begin
        cnt = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic rw, input logic [31:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int cyc);
    @(negedge clk);
    log_n = 0;
    cpu_valid = 1'b1; cpu_rw = rw; cpu_addr = a; cpu_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready && cyc < 2000);
    rd = cpu_rdata;
    cpu_valid = 1'b0;
    if (cyc >= 2000) check(1'b0, "R9", "access timeout", 128'(cyc), 128'd0);
    @(negedge clk);
    check(cpu_ready == 1'b0, "R11", "ready pulse length", 128'(cpu_ready), 128'd0);
  endtask

  typedef struct packed {
    logic        rw;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        exp_fill;
    logic        exp_wb;
    logic [31:0] wb_addr;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0000_0010, 32'h0,         1'b1, 1'b0, 32'h0},         // R1 R5 cold miss
    '{1'b0, 32'h0000_0014, 32'h0,         1'b0, 1'b0, 32'h0},         // R3 read hit
    '{1'b1, 32'h0000_0018, 32'h1111_1111, 1'b0, 1'b0, 32'h0},         // R4 write hit
    '{1'b0, 32'h0000_0018, 32'h0,         1'b0, 1'b0, 32'h0},         // R4 reads back
    '{1'b0, 32'h0000_4010, 32'h0,         1'b1, 1'b1, 32'h0000_0010}, // R2 R7 alias, dirty victim
    '{1'b0, 32'h0000_0018, 32'h0,         1'b1, 1'b0, 32'h0},         // R5 clean victim, data from memory
    '{1'b1, 32'h0000_8020, 32'h2222_2222, 1'b1, 1'b0, 32'h0},         // R6 write miss
    '{1'b0, 32'h0000_8020, 32'h0,         1'b0, 1'b0, 32'h0},         // R6 merged word
    '{1'b0, 32'h0000_8024, 32'h0,         1'b0, 1'b0, 32'h0},         // R6 neighbour word kept
    '{1'b1, 32'h0000_0023, 32'h3333_3333, 1'b1, 1'b1, 32'h0000_8020}, // R12 R7 byte offset, dirty victim
    '{1'b0, 32'h0000_0020, 32'h0,         1'b0, 1'b0, 32'h0},         // R12 word updated
    '{1'b0, 32'h0000_8020, 32'h0,         1'b1, 1'b1, 32'h0000_0020}, // R7 R2 dirty victim
    '{1'b0, 32'h0003_FFFC, 32'h0,         1'b1, 1'b0, 32'h0},         // R2 last index
    '{1'b1, 32'h0003_FFFC, 32'h4444_4444, 1'b0, 1'b0, 32'h0},         // R4 hit at last index
    '{1'b0, 32'hFFFF_FFF0, 32'h0,         1'b1, 1'b1, 32'h0003_FFF0}, // R2 R7 max tag
    '{1'b0, 32'h0003_FFFC, 32'h0,         1'b1, 1'b0, 32'h0}          // R5 returns written-back word
  };

  task automatic run_vec(input vec_t v);
    logic [31:0]  rd;
    logic [127:0] exp_line;
    int           cyc;
    int           exp_n;
    exp_n    = int'(v.exp_fill) + int'(v.exp_wb);
    exp_line = v.exp_wb ? gline(v.wb_addr) : '0;
    access(v.rw, v.addr, v.wdata, rd, cyc);
    check(log_n == exp_n, "R5", "memory transfer count", 128'(log_n), 128'(exp_n));
    if (v.exp_wb && log_n >= 1) begin
      check(log_rw[0] == 1'b1, "R7", "write-back first", 128'(log_rw[0]), 128'd1);
      check(log_addr[0] == v.wb_addr, "R7", "write-back address",
            128'(log_addr[0]), 128'(v.wb_addr));
      check(log_data[0] == exp_line, "R7", "write-back line", log_data[0], exp_line);
    end
    if (v.exp_fill && log_n == exp_n) begin
      check(log_rw[exp_n-1] == 1'b0, "R5", "refill is a read", 128'(log_rw[exp_n-1]), 128'd0);
      check(log_addr[exp_n-1] == {v.addr[31:4], 4'h0}, "R5", "refill address",
            128'(log_addr[exp_n-1]), 128'({v.addr[31:4], 4'h0}));
      check(cyc >= 4, "R9", "miss latency", 128'(cyc), 128'd4);
    end
    if (!v.exp_fill)
      check(cyc == 2, "R3", "hit latency", 128'(cyc), 128'd2);
    if (!v.rw)
      check(rd == gword(v.addr), "R3", "read data", 128'(rd), 128'(gword(v.addr)));
    else
      gold[{v.addr[31:2], 2'b00}] = v.wdata;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int cyc;
    repeat (3) @(negedge clk);
    check(cpu_ready == 1'b0 && mem_valid == 1'b0, "R1", "outputs in reset",
          128'({cpu_ready, mem_valid}), 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check(cpu_ready == 1'b0 && mem_valid == 1'b0, "R1", "outputs after reset",
          128'({cpu_ready, mem_valid}), 128'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1: reset discards a modified line; no write-back follows.
    access(1'b1, 32'h0000_0014, 32'h5555_5555, rd, cyc);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    gold.delete(32'h0000_0014);
    access(1'b0, 32'h0000_4014, 32'h0, rd, cyc);
    check(log_n == 1 && log_rw[0] == 1'b0, "R1", "no write-back after reset",
          128'(log_n), 128'd1);
    check(rd == gword(32'h0000_4014), "R1", "read after reset", 128'(rd),
          128'(gword(32'h0000_4014)));
    access(1'b0, 32'h0000_0014, 32'h0, rd, cyc);
    check(log_n == 1, "R1", "line invalid after reset", 128'(log_n), 128'd1);
    check(rd == gword(32'h0000_0014), "R1", "memory value kept", 128'(rd),
          128'(gword(32'h0000_0014)));

    // R12: low address bits ignored on read.
    access(1'b0, 32'h0000_0017, 32'h0, rd, cyc);
    check(rd == gword(32'h0000_0014) && cyc == 2, "R12", "byte offset read", 128'(rd),
          128'(gword(32'h0000_0014)));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule